// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block sits between a small on-chip staging FIFO, which collects the bytes of received frames, and a byte-addressed write port into a contiguous ring buffer in host memory. Bytes are taken out of the staging FIFO only after enough of them have accumulated to meet a programmable threshold, or once the end of a frame is already buffered. The block then writes them one per cycle into the ring, four bytes past the start of the current frame slot.

When a frame's last byte has been stored, the block fills in a four-byte header in front of the data. The header holds a 16-bit status word and a 16-bit byte count. It then moves its write offset to the next word boundary after the frame, pulses a completion flag and starts the next frame. A software read offset bounds how far the writer may advance. A frame that would run into it is abandoned and flagged.

By default, frame data that runs past the end of the ring continues at offset zero. With the spill option set, the data instead keeps going into a reserved area past the ring end, so that every frame lies in one contiguous piece. The next frame still begins at the wrapped offset.

Top module: `rxr_writer`

## Requirements
- R1: While reset is held at a clock edge, the following cycle shows `mem_we`, `irq_ok`, `irq_err` and `ovf` low, `wr_ptr` at 0 and `in_ready` high.
- R2: Data byte k (counting from 0) of a frame that starts at offset W is written to address W+4+k, in arrival order, one write per cycle.
- R3: After a frame's last data byte, four header bytes are written to addresses W..W+3 in this order: status low, status high, length low, length high. The length is the number of data bytes received for the frame. The status word has bit 0 = receive OK, bit 1 = alignment error, bit 2 = CRC error, bit 3 = over-long, bit 4 = runt, bit 5 = own-address match and bit 6 = multicast, and bits 15..7 are zero. These come from `in_status` bits 0..5 in the same order.
- R4: Receive OK is 1 exactly when `in_status[3:0]` is zero. A completed frame pulses `irq_ok` (when OK) or `irq_err` (when not) for one cycle, in the same cycle as the last header write, and never both.
- R5: No byte is written while fewer than `thresh` bytes sit in the staging FIFO and no frame end is among them.
- R6: After a stored frame, `wr_ptr` becomes (W+4+length) rounded up to a multiple of 4, modulo `RING_BYTES`. It changes at no other time.
- R7: With `wrap_en` low, a data address W+4+k at or past `RING_BYTES` is written at W+4+k-`RING_BYTES`.
- R8: With `wrap_en` high, data addresses continue past `RING_BYTES` without wrapping.
- R9: Let D be the word distance from `wr_ptr` up to `rd_ptr` around the ring, with D taken as the full ring when the two are equal. A data byte k is stored only while ((4+k)/4)+1 < D (integer division). The first byte that fails this test, and all later bytes of that frame, are discarded. At the frame's end, `ovf` and `irq_err` pulse together, no header is written and `wr_ptr` keeps its value.
- R10: `in_ready` goes low while the staging FIFO is full, and every byte accepted while it is high is eventually handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wrap_en | input | 1 | 1: frame data spills past the ring end instead of wrapping |
| thresh | input | CW | Number of buffered bytes that starts a move to memory |
| rd_ptr | input | PW | Software read offset into the ring, word aligned |
| in_valid | input | 1 | Received byte is offered |
| in_ready | output | 1 | Staging FIFO can take a byte |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Offered byte is the last of its frame |
| in_status | input | 6 | Frame status, valid with `in_last`: 0 align, 1 CRC, 2 long, 3 runt, 4 address match, 5 multicast |
| mem_we | output | 1 | Ring write strobe |
| mem_addr | output | AW | Ring byte address, including the spill area |
| mem_data | output | 8 | Ring write byte |
| wr_ptr | output | PW | Start offset of the frame slot being filled |
| irq_ok | output | 1 | One-cycle pulse: frame stored without error |
| irq_err | output | 1 | One-cycle pulse: frame stored with error, or dropped |
| ovf | output | 1 | One-cycle pulse: frame dropped for lack of room |

## Verification
The assertions take several things for granted about the inputs. `rd_ptr` is word aligned and inside the ring, and `thresh` lies between 1 and the FIFO depth. `wrap_en` and `thresh` hold still while a frame is moving. The spill area is large enough for any frame that crosses the ring end. The bench changes `wrap_en`, `thresh` and `rd_ptr` only after all earlier frames have been written and the queues are empty. It keeps `rd_ptr` on word boundaries and keeps frames short enough that a spilled frame stays well inside the reserved area.

// File: rtl/rxr_pkg.sv
// Shared definitions for the receive ring writer.
// Assumes a fixed 16-bit length field in the frame header.
package rxr_pkg;
    localparam int LEN_W = 16;

    // Status word bit positions written into the header.
    localparam int ST_OK    = 0;
    localparam int ST_ALIGN = 1;
    localparam int ST_CRC   = 2;
    localparam int ST_LONG  = 3;
    localparam int ST_RUNT  = 4;
    localparam int ST_ADDR  = 5;
    localparam int ST_MCAST = 6;

    typedef enum logic {
        PH_DATA = 1'b0,
        PH_HDR  = 1'b1
    } phase_t;
endpackage

// File: rtl/rxr_stage_fifo.sv
// Staging FIFO for received bytes with their end-of-frame tag and status.
// Assumes no push when full and no pop when empty; read data is combinational.
module rxr_stage_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 15,
    localparam int AW_F = $clog2(DEPTH),
    localparam int CW   = AW_F + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);
    logic [W-1:0]    mem [DEPTH];
    logic [AW_F-1:0] wp, rp;

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= (wp == AW_F'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == AW_F'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign dout = mem[rp];
endmodule

// File: rtl/rxr_room.sv
// Decides whether data byte k of the current frame still fits in front of
// the software read offset, reserving the frame's padded footprint.
// Assumes word-aligned offsets inside the ring.
module rxr_room #(
    parameter int RING_BYTES = 2048,
    localparam int PW = $clog2(RING_BYTES),
    localparam int XW = rxr_pkg::LEN_W + 1
) (
    input  logic [PW-1:0]              wr_ptr,
    input  logic [PW-1:0]              rd_ptr,
    input  logic [rxr_pkg::LEN_W-1:0]  k,
    output logic                       fits
);
    localparam logic [XW-1:0] RW = XW'(RING_BYTES / 4);

    logic [XW-1:0] wrw, rdw, room_w, need;

    // Word distance to the reader and words needed after this byte.
    always_comb begin
        wrw    = XW'(wr_ptr >> 2);
        rdw    = XW'(rd_ptr >> 2);
        room_w = (rdw > wrw) ? rdw - wrw : rdw + RW - wrw;
        need   = ((XW'(k) + XW'(4)) >> 2) + XW'(1);
        fits   = need < room_w;
    end
endmodule

// File: rtl/rxr_writer.sv
// Receive ring writer: moves staged frame bytes into a host ring, prefixes
// each frame with a status/length header, advances the write offset and
// drops frames that would overtake the reader.
// Assumes the memory port accepts one byte per cycle and rd_ptr is word aligned.
module rxr_writer #(
    parameter int RING_BYTES  = 2048,
    parameter int SPILL_BYTES = 1536,
    parameter int FIFO_DEPTH  = 16,
    localparam int PW = $clog2(RING_BYTES),
    localparam int AW = $clog2(RING_BYTES + SPILL_BYTES),
    localparam int CW = $clog2(FIFO_DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wrap_en,
    input  logic [CW-1:0] thresh,
    input  logic [PW-1:0] rd_ptr,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    input  logic [5:0]    in_status,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_data,
    output logic [PW-1:0] wr_ptr,
    output logic          irq_ok,
    output logic          irq_err,
    output logic          ovf
);
    import rxr_pkg::*;

    localparam int FW = 15;
    localparam int SW = LEN_W + 2;
    localparam logic [SW-1:0] RING_S = SW'(RING_BYTES);

    phase_t            phase;
    logic [LEN_W-1:0]  k, len_r;
    logic [5:0]        st_r;
    logic [1:0]        hidx;
    logic              drop;
    logic [CW-1:0]     fcnt, lastq;
    logic [FW-1:0]     fout;
    logic              push, pop, fits, f_last;
    logic [SW-1:0]     dsum, dwrap, tot, nxt;
    logic [15:0]       stat_w;
    logic [7:0]        hbyte;

    assign in_ready = (fcnt != CW'(FIFO_DEPTH));
    assign push     = in_valid && in_ready;
    assign f_last   = fout[14];

    rxr_stage_fifo #(.DEPTH(FIFO_DEPTH), .W(FW)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   ({in_last, in_status, in_data}),
        .pop   (pop),
        .dout  (fout),
        .count (fcnt)
    );

    rxr_room #(.RING_BYTES(RING_BYTES)) u_room (
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .k      (k),
        .fits   (fits)
    );

    // Drain when threshold reached or a frame end is buffered.
    always_comb begin
        pop = (phase == PH_DATA) && (fcnt != '0) && ((fcnt >= thresh) || (lastq != '0));
    end

    // Data address, next slot offset and header byte selection.
    always_comb begin
        dsum   = SW'(wr_ptr) + SW'(4) + SW'(k);
        dwrap  = (!wrap_en && dsum >= RING_S) ? dsum - RING_S : dsum;
        tot    = (SW'(wr_ptr) + SW'(4) + SW'(len_r) + SW'(3)) & ~SW'(3);
        nxt    = (tot >= RING_S) ? tot - RING_S : tot;
        stat_w = {9'b0, st_r, (st_r[3:0] == 4'b0)};
        case (hidx)
            2'd0:    hbyte = stat_w[7:0];
            2'd1:    hbyte = stat_w[15:8];
            2'd2:    hbyte = len_r[7:0];
            default: hbyte = len_r[15:8];
        endcase
    end

    // Count of frame ends currently held in the staging FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n) lastq <= '0;
        else        lastq <= lastq + CW'(push && in_last) - CW'(pop && f_last);
    end

    // Frame sequencing: data bytes, then header, then offset update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_DATA;
            k        <= '0;
            len_r    <= '0;
            st_r     <= '0;
            hidx     <= '0;
            drop     <= 1'b0;
            wr_ptr   <= '0;
            mem_we   <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
            irq_ok   <= 1'b0;
            irq_err  <= 1'b0;
            ovf      <= 1'b0;
        end else begin
            mem_we  <= 1'b0;
            irq_ok  <= 1'b0;
            irq_err <= 1'b0;
            ovf     <= 1'b0;
            if (phase == PH_HDR) begin
                mem_we   <= 1'b1;
                mem_addr <= AW'(wr_ptr) + AW'(hidx);
                mem_data <= hbyte;
                hidx     <= hidx + 2'd1;
                if (hidx == 2'd3) begin
                    phase   <= PH_DATA;
                    k       <= '0;
                    wr_ptr  <= PW'(nxt);
                    irq_ok  <= (st_r[3:0] == 4'b0);
                    irq_err <= (st_r[3:0] != 4'b0);
                end
            end else if (pop) begin
                if (drop || !fits) begin
                    drop <= !f_last;
                    if (f_last) begin
                        k       <= '0;
                        irq_err <= 1'b1;
                        ovf     <= 1'b1;
                    end
                end else begin
                    mem_we   <= 1'b1;
                    mem_addr <= AW'(dwrap);
                    mem_data <= fout[7:0];
                    if (f_last) begin
                        len_r <= k + 1'b1;
                        st_r  <= fout[13:8];
                        hidx  <= 2'd0;
                        phase <= PH_HDR;
                    end else begin
                        k <= k + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rxr_writer_chk.sv
// Property checker for rxr_writer, attached by bind.
// Assumes the input conditions listed in the brief.
module rxr_writer_chk #(
    parameter int RING_BYTES  = 2048,
    parameter int SPILL_BYTES = 1536,
    localparam int PW = $clog2(RING_BYTES),
    localparam int AW = $clog2(RING_BYTES + SPILL_BYTES)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wrap_en,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [PW-1:0] wr_ptr,
    input logic          irq_ok,
    input logic          irq_err,
    input logic          ovf
);
    localparam logic [PW:0] RING_P = (PW+1)'(RING_BYTES);
    localparam logic [AW:0] RING_A = (AW+1)'(RING_BYTES);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!mem_we && !irq_ok && !irq_err && !ovf && wr_ptr == '0));

    // R4
    irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_ok && irq_err));

    // R9
    ovf_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (irq_err && !irq_ok));

    // R9
    ovf_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (wr_ptr == $past(wr_ptr)));

    // R6
    ptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr[1:0] == 2'b00) && ({1'b0, wr_ptr} < RING_P));

    // R6
    ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr != $past(wr_ptr)) |-> ((irq_ok || irq_err) && !ovf));

    // R7
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !wrap_en) |-> ({1'b0, mem_addr} < RING_A));
endmodule

bind rxr_writer rxr_writer_chk #(
    .RING_BYTES  (RING_BYTES),
    .SPILL_BYTES (SPILL_BYTES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrap_en  (wrap_en),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .wr_ptr   (wr_ptr),
    .irq_ok   (irq_ok),
    .irq_err  (irq_err),
    .ovf      (ovf)
);

// File: tb/rxr_writer_bench.sv
// Scoreboard bench: the frame driver predicts ring writes and completion
// pulses into queues; a monitor compares them as the design produces them.
module rxr_writer_bench;
    localparam int RING  = 2048;
    localparam int SPILL = 1536;
    localparam int DEPTH = 16;
    localparam int PW = $clog2(RING);
    localparam int AW = $clog2(RING + SPILL);
    localparam int CW = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wrap_en = 1'b0;
    logic [CW-1:0] thresh = CW'(4);
    logic [PW-1:0] rd_ptr = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    in_data = '0;
    logic          in_last = 1'b0;
    logic [5:0]    in_status = '0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_data;
    logic [PW-1:0] wr_ptr;
    logic          irq_ok, irq_err, ovf;

    rxr_writer #(.RING_BYTES(RING), .SPILL_BYTES(SPILL), .FIFO_DEPTH(DEPTH)) u_rxr_writer (
        .clk(clk), .rst_n(rst_n), .wrap_en(wrap_en), .thresh(thresh), .rd_ptr(rd_ptr),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .in_status(in_status), .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .wr_ptr(wr_ptr), .irq_ok(irq_ok), .irq_err(irq_err), .ovf(ovf)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int n_wr = 0;
    int W = 0;
    int R = 0;
    bit saw_busy = 0;
    bit done = 0;

    int    q_addr[$];
    int    q_data[$];
    string q_wtag[$];
    int    q_irq[$];
    string q_itag[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: compare writes and completion pulses with predictions.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!in_ready) saw_busy = 1;
            if (mem_we) begin
                n_wr++;
                if (q_addr.size() == 0) begin
                    check(0, "R2 unexpected write", int'(mem_addr), -1);
                end else begin
                    int ea, ed;
                    string et;
                    ea = q_addr.pop_front();
                    ed = q_data.pop_front();
                    et = q_wtag.pop_front();
                    check(int'(mem_addr) == ea, {et, " addr"}, int'(mem_addr), ea);
                    check(int'(mem_data) == ed, {et, " data"}, int'(mem_data), ed);
                end
            end
            if (irq_ok || irq_err || ovf) begin
                int act;
                act = {29'b0, irq_ok, irq_err, ovf};
                if (q_irq.size() == 0) begin
                    check(0, "R4 unexpected pulse", act, 0);
                end else begin
                    int e;
                    string t;
                    e = q_irq.pop_front();
                    t = q_irq.size() >= 0 ? q_itag.pop_front() : "";
                    check(act == e, {t, " pulses ok/err/ovf"}, act, e);
                end
            end
        end
    end

    task automatic push_byte(input logic [7:0] b, input logic last, input logic [5:0] st);
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        in_valid  = 1'b1;
        in_data   = b;
        in_last   = last;
        in_status = st;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    // Predict a frame's effect, then drive its bytes.
    task automatic send_frame(input int len, input logic [5:0] st, input int seed, input int pause_at);
        int dw, n0;
        bit dropped;
        bit okb;
        dropped = 0;
        dw = (R >> 2) - (W >> 2);
        if (dw <= 0) dw += RING / 4;
        for (int k = 0; k < len; k++) begin
            if ((((4 + k) >> 2) + 1) < dw) begin
                int a;
                string t;
                a = W + 4 + k;
                t = "R2";
                if (a >= RING) begin
                    if (wrap_en) t = "R8";
                    else begin a -= RING; t = "R7"; end
                end
                q_addr.push_back(a); q_data.push_back((seed + k) & 255); q_wtag.push_back(t);
            end else begin
                dropped = 1;
                break;
            end
        end
        if (dropped) begin
            q_irq.push_back(3); q_itag.push_back("R9");
        end else begin
            okb = (st[3:0] == 4'b0);
            q_addr.push_back(W);     q_data.push_back({st, okb}); q_wtag.push_back("R3");
            q_addr.push_back(W + 1); q_data.push_back(0);          q_wtag.push_back("R3");
            q_addr.push_back(W + 2); q_data.push_back(len & 255);  q_wtag.push_back("R3");
            q_addr.push_back(W + 3); q_data.push_back(len >> 8);   q_wtag.push_back("R3");
            q_irq.push_back(okb ? 4 : 2); q_itag.push_back("R4");
            W = ((W + 4 + len + 3) & ~3) % RING;
        end
        n0 = n_wr;
        for (int k = 0; k < len; k++) begin
            if (k == pause_at) begin
                repeat (10) @(negedge clk);
                // R5: below threshold, nothing may reach memory
                check(n_wr == n0, "R5 early write", n_wr, n0);
            end
            push_byte(8'((seed + k) & 255), k == len - 1, st);
        end
    endtask

    task automatic drain();
        while (q_addr.size() != 0 || q_irq.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic set_rd(input int r);
        R = r;
        rd_ptr = PW'(r);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(!mem_we && !irq_ok && !irq_err && !ovf, "R1 outputs idle", int'(mem_we), 0);
        check(wr_ptr == '0, "R1 wr_ptr", int'(wr_ptr), 0);
        check(in_ready, "R1 in_ready", int'(in_ready), 1);
        rst_n = 1'b1;

        // R2 R3 R4 R6: good frame, then errored frame
        send_frame(10, 6'b010000, 8'h30, -1);
        drain();
        check(int'(wr_ptr) == W, "R6 wr_ptr after 10", int'(wr_ptr), W);
        send_frame(7, 6'b100010, 8'h50, -1);
        drain();
        check(int'(wr_ptr) == W, "R6 wr_ptr after 7", int'(wr_ptr), W);
        send_frame(5, 6'b001001, 8'h70, -1);
        drain();

        // R5: threshold holds bytes back
        thresh = CW'(12);
        send_frame(20, 6'b000000, 8'h90, 6);
        drain();

        // R10: back-pressure with full FIFO
        thresh = CW'(16);
        saw_busy = 0;
        send_frame(40, 6'b100000, 8'hA0, -1);
        drain();
        check(saw_busy, "R10 in_ready low when full", int'(saw_busy), 1);

        // R7: cross the ring end without spill
        thresh = CW'(4);
        while (W <= 1800) begin
            set_rd(W);
            send_frame(200, 6'b000000, W & 255, -1);
            drain();
        end
        set_rd(W);
        send_frame(300, 6'b010000, 8'h11, -1);
        drain();
        check(int'(wr_ptr) == W, "R7 wr_ptr after wrap", int'(wr_ptr), W);

        // R8: cross the ring end with spill
        wrap_en = 1'b1;
        while (W <= 1800) begin
            set_rd(W);
            send_frame(200, 6'b000000, W & 255, -1);
            drain();
        end
        set_rd(W);
        send_frame(300, 6'b000100, 8'h22, -1);
        drain();
        check(int'(wr_ptr) == W, "R8 wr_ptr after spill", int'(wr_ptr), W);
        wrap_en = 1'b0;

        // R9: reader too close, frame dropped, pointer held
        set_rd((W + 64) % RING);
        begin
            int w0;
            w0 = W;
            send_frame(100, 6'b000000, 8'h33, -1);
            drain();
            check(int'(wr_ptr) == w0, "R9 wr_ptr held", int'(wr_ptr), w0);
        end
        send_frame(8, 6'b010000, 8'h44, -1);
        drain();
        check(int'(wr_ptr) == W, "R6 wr_ptr after recovery", int'(wr_ptr), W);

        check(q_addr.size() == 0, "R2 writes outstanding", q_addr.size(), 0);
        check(q_irq.size() == 0, "R4 pulses outstanding", q_irq.size(), 0);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule